// File: doc/BRIEF.md
# Program Counter and Call/Return Sequencer

This unit owns the program counter and the stack pointer of a small 8-bit processor with a 16-bit address space. An instruction decoder hands it one control-flow command at a time. Each command is either a plain advance past a non-branching instruction or a branch: an absolute jump or call, a jump or call through the fixed register pair w3, a signed 8-bit relative jump, or a return. Any branch may be made conditional on one of eight tests of the zero, carry, overflow and negative flags.

Where a branch carries immediate operand bytes, the unit fetches them itself from the bytes that follow the opcode. For calls and returns it runs the byte-wide stack cycles. The unit drives a single byte-wide memory port, and I/O sits in the same address map. Every cycle on that port is tagged as an instruction, data or stack access, so a system can keep those spaces apart. The decoder presents commands on a valid/ready pair. A command is taken only when both are high. `cmd_ready` stays low from the acceptance of a multi-cycle command until the new counter value is in place, and a waiting command must stay stable during that time. The memory port holds its request until the memory acknowledges it.

Top module: `flow_ctl`

## Requirements
- R1: After reset the program counter is 0x0000, the stack pointer equals the SP_INIT parameter (default 0x0000), `cmd_ready` is high and no memory request is active.
- R2: Command code 0 (advance) adds the 2-bit `cmd_len` field to the counter in the accepting cycle and issues no memory cycle.
- R3: Command code 1 (absolute jump) reads the low target byte at PC+1 and then the high byte at PC+2, both with space code 0 (instruction). A taken jump loads that target.
- R4: Command code 3 (relative jump) reads one displacement byte at PC+1. A taken jump loads PC+2 plus the sign-extended displacement, modulo 2^16.
- R5: Command codes 2 (jump through w3) and 5 (call through w3) use the value on `w3` in the accepting cycle as the target. A skipped code-2 jump leaves PC+1.
- R6: A taken call pushes its return address, which is PC+3 for code 4 (absolute call) and PC+1 for code 5. The high byte is written to SP-1 and then the low byte to SP-2, both with space code 2 (stack). SP drops by 2, and the counter then takes the target.
- R7: A taken return (code 6) reads the low byte at SP and then the high byte at SP+1 with space code 2. The counter takes the 16-bit value, and SP rises by 2.
- R8: `cmd_cond` bits [2:1] select the flag (0 zero, 1 carry, 2 overflow, 3 negative, at those bit positions of `flags`). Bit 0 set means the flag must be clear. The test uses the flags of the accepting cycle, and `cmd_cond_en` low makes the branch unconditional.
- R9: A branch whose test fails still reads its operand bytes, and the counter moves just past them. It runs no stack cycle and leaves SP unchanged.
- R10: Only one memory cycle is in flight at a time. Address, direction and space stay stable until `mem_ack`. `cmd_ready` stays low, and the counter stays unchanged, until the command has finished.
- R11: Command code 7 is reserved and advances the counter by 1 with no memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered by decoder |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 3 | Command code |
| cmd_cond_en | input | 1 | Branch is conditional |
| cmd_cond | input | 3 | Condition select |
| cmd_len | input | 2 | Byte length for advance command |
| flags | input | 4 | {negative, overflow, carry, zero} |
| w3 | input | AW | Register pair w3 |
| pc | output | AW | Program counter |
| sp | output | AW | Stack pointer |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write byte |
| mem_space | output | 2 | 0 instruction, 1 data, 2 stack |
| mem_rdata | input | DW | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Memory cycle complete |

## Verification
A condition test and a flag update can fall in the same cycle. The flags an ALU writes may change in the cycle right after a conditional branch is accepted, while the unit is still fetching that branch's operands. The bench changes every flag to its opposite immediately after acceptance and expects the decision to follow the flags that were present when the command was taken. A second overlap is a new command offered while a call is still busy. That command must be held back and must land only after the call's last stack write.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [2:0] {
    OP_NEXT  = 3'd0,
    OP_JP    = 3'd1,
    OP_JPW   = 3'd2,
    OP_JR    = 3'd3,
    OP_CALL  = 3'd4,
    OP_CALLW = 3'd5,
    OP_RET   = 3'd6,
    OP_RSVD  = 3'd7
  } flow_op_e;

  typedef enum logic [1:0] {
    SPC_INSN  = 2'd0,
    SPC_DATA  = 2'd1,
    SPC_STACK = 2'd2
  } mem_space_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPND_LO,
    ST_OPND_HI,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_LO,
    ST_POP_HI
  } flow_state_e;

endpackage

// File: rtl/flow_cond.sv
module flow_cond #(
  parameter int FLAG_W = 4,
  localparam int SEL_W  = $clog2(FLAG_W),
  localparam int CODE_W = SEL_W + 1
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [CODE_W-1:0] code,
  input  logic              enable,
  output logic              met
);
  logic [SEL_W-1:0] sel;

  always_comb begin
    sel = code[CODE_W-1:1];
    // bit 0 of the code inverts the selected flag
    met = !enable || (flags[sel] ^ code[0]);
  end
endmodule

// File: rtl/flow_addr.sv
module flow_addr #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LEN_W = 2
) (
  input  logic [AW-1:0]    pc,
  input  logic [LEN_W-1:0] len,
  input  logic [DW-1:0]    disp,
  output logic [AW-1:0]    seq_step,
  output logic [AW-1:0]    seq1,
  output logic [AW-1:0]    seq2,
  output logic [AW-1:0]    seq3,
  output logic [AW-1:0]    rel_tgt
);
  localparam logic [AW-1:0] ONE   = AW'(1);
  localparam logic [AW-1:0] TWO   = AW'(2);
  localparam logic [AW-1:0] THREE = AW'(3);

  logic [AW-1:0] disp_ext;

  always_comb begin
    disp_ext = {{(AW-DW){disp[DW-1]}}, disp};
    seq_step = pc + AW'(len);
    seq1     = pc + ONE;
    seq2     = pc + TWO;
    seq3     = pc + THREE;
    rel_tgt  = seq2 + disp_ext;
  end
endmodule

// File: rtl/flow_stack.sv
module flow_stack #(
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] push_addr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SP_INIT;
    end else if (dec) begin
      sp_q <= sp_q - ONE;
    end else if (inc) begin
      sp_q <= sp_q + ONE;
    end
  end

  assign sp        = sp_q;
  assign push_addr = sp_q - ONE;
endmodule

// File: rtl/flow_ctl.sv
module flow_ctl
  import flow_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] SP_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_cond_en,
  input  logic [2:0]    cmd_cond,
  input  logic [1:0]    cmd_len,
  input  logic [3:0]    flags,
  input  logic [AW-1:0] w3,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] sp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [1:0]    mem_space,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  // a target is assembled from two operand or stack bytes
  localparam int HI_W = AW - DW;

  flow_state_e   state;
  flow_op_e      op_q;
  flow_op_e      op_in;
  logic          taken_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] lo_q;
  logic [AW-1:0] link_q;
  logic [AW-1:0] dest_q;

  logic          accept;
  logic          cond_met;
  logic [AW-1:0] seq_step, seq1, seq2, seq3, rel_tgt;
  logic [AW-1:0] push_addr;
  logic          sp_dec, sp_inc;
  logic [AW-1:0] byte_pair;

  assign op_in     = flow_op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign byte_pair = {mem_rdata[HI_W-1:0], lo_q};
  assign pc        = pc_q;

  flow_cond #(.FLAG_W(4)) u_cond (
    .flags  (flags),
    .code   (cmd_cond),
    .enable (cmd_cond_en),
    .met    (cond_met)
  );

  flow_addr #(.AW(AW), .DW(DW), .LEN_W(2)) u_addr (
    .pc       (pc_q),
    .len      (cmd_len),
    .disp     (mem_rdata),
    .seq_step (seq_step),
    .seq1     (seq1),
    .seq2     (seq2),
    .seq3     (seq3),
    .rel_tgt  (rel_tgt)
  );

  assign sp_dec = mem_ack && (state == ST_PUSH_HI || state == ST_PUSH_LO);
  assign sp_inc = mem_ack && (state == ST_POP_LO  || state == ST_POP_HI);

  flow_stack #(.AW(AW), .SP_INIT(SP_INIT)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (sp_dec),
    .inc       (sp_inc),
    .sp        (sp),
    .push_addr (push_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_NEXT;
      taken_q <= 1'b0;
      pc_q    <= '0;
      lo_q    <= '0;
      link_q  <= '0;
      dest_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= op_in;
            taken_q <= cond_met;
            case (op_in)
              OP_NEXT: pc_q <= seq_step;
              OP_JPW:  pc_q <= cond_met ? w3 : seq1;
              OP_CALLW: begin
                if (cond_met) begin
                  link_q <= seq1;
                  dest_q <= w3;
                  state  <= ST_PUSH_HI;
                end else begin
                  pc_q <= seq1;
                end
              end
              OP_RET: begin
                if (cond_met) state <= ST_POP_LO;
                else          pc_q  <= seq1;
              end
              OP_JP, OP_JR, OP_CALL: state <= ST_OPND_LO;
              default: pc_q <= seq1;
            endcase
          end
        end
        ST_OPND_LO: begin
          if (mem_ack) begin
            lo_q <= mem_rdata;
            if (op_q == OP_JR) begin
              pc_q  <= taken_q ? rel_tgt : seq2;
              state <= ST_IDLE;
            end else begin
              state <= ST_OPND_HI;
            end
          end
        end
        ST_OPND_HI: begin
          if (mem_ack) begin
            if (!taken_q) begin
              pc_q  <= seq3;
              state <= ST_IDLE;
            end else if (op_q == OP_CALL) begin
              link_q <= seq3;
              dest_q <= byte_pair;
              state  <= ST_PUSH_HI;
            end else begin
              pc_q  <= byte_pair;
              state <= ST_IDLE;
            end
          end
        end
        ST_PUSH_HI: if (mem_ack) state <= ST_PUSH_LO;
        ST_PUSH_LO: begin
          if (mem_ack) begin
            pc_q  <= dest_q;
            state <= ST_IDLE;
          end
        end
        ST_POP_LO: begin
          if (mem_ack) begin
            lo_q  <= mem_rdata;
            state <= ST_POP_HI;
          end
        end
        ST_POP_HI: begin
          if (mem_ack) begin
            pc_q  <= byte_pair;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_space = SPC_INSN;
    case (state)
      ST_OPND_LO: begin
        mem_req  = 1'b1;
        mem_addr = seq1;
      end
      ST_OPND_HI: begin
        mem_req  = 1'b1;
        mem_addr = seq2;
      end
      ST_PUSH_HI: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = push_addr;
        mem_wdata = link_q[AW-1:AW-DW];
        mem_space = SPC_STACK;
      end
      ST_PUSH_LO: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = push_addr;
        mem_wdata = link_q[DW-1:0];
        mem_space = SPC_STACK;
      end
      ST_POP_LO, ST_POP_HI: begin
        mem_req   = 1'b1;
        mem_addr  = sp;
        mem_space = SPC_STACK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flow_ctl_chk.sv
module flow_ctl_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] sp,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_space,
  input logic          mem_ack
);
  localparam logic [AW-1:0] ONE = AW'(1);

  AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_space)); // R10
  AST_BUSY_HAS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> mem_req); // R10
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready && !mem_ack |=> $stable(pc)); // R10
  AST_IDLE_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req); // R2
  AST_WRITE_IS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_space == 2'd2); // R6
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> sp == $past(sp) - ONE); // R6
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_space == 2'd2 && mem_ack |=> sp == $past(sp) + ONE); // R7
endmodule

bind flow_ctl flow_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .pc        (pc),
  .sp        (sp),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_space (mem_space),
  .mem_ack   (mem_ack)
);

// File: tb/flow_ctl_test.sv
module flow_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic        cmd_cond_en = 1'b0;
  logic [2:0]  cmd_cond = '0;
  logic [1:0]  cmd_len = '0;
  logic [3:0]  flags = '0;
  logic [15:0] w3 = '0;
  logic [15:0] pc, sp;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [1:0]  mem_space;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int tests = 0;
  int fails = 0;

  logic [7:0]  mem [0:255];
  logic [15:0] lg_addr [0:63];
  logic [7:0]  lg_data [0:63];
  logic        lg_we   [0:63];
  logic [1:0]  lg_spc  [0:63];
  int          lg_n = 0;

  flow_ctl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_cond_en(cmd_cond_en), .cmd_cond(cmd_cond), .cmd_len(cmd_len),
    .flags(flags), .w3(w3), .pc(pc), .sp(sp), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_space(mem_space),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // byte memory aliased on the low address byte, one-cycle acknowledge
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
      if (lg_n < 64) begin
        lg_addr[lg_n] <= mem_addr;
        lg_data[lg_n] <= mem_we ? mem_wdata : mem[mem_addr[7:0]];
        lg_we[lg_n]   <= mem_we;
        lg_spc[lg_n]  <= mem_space;
      end
      lg_n <= lg_n + 1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic chk_txn(input string req, input int idx, input int addr,
                         input bit we, input int data, input int spc);
    chk_eq(req, "txn addr", int'(lg_addr[idx]), addr);
    chk_eq(req, "txn we", int'(lg_we[idx]), int'(we));
    chk_eq(req, "txn data", int'(lg_data[idx]), data);
    chk_eq(req, "txn space", int'(lg_spc[idx]), spc);
  endtask

  task automatic issue(input logic [2:0] op, input bit ce, input logic [2:0] cc,
                       input logic [1:0] len, input logic [3:0] fl,
                       input logic [15:0] wv, input bit flip);
    @(negedge clk);
    cmd_op = op; cmd_cond_en = ce; cmd_cond = cc; cmd_len = len;
    flags = fl; w3 = wv; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (flip) flags = ~fl;
    w3 = ~wv;
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic set_pc(input logic [15:0] v);
    issue(3'd2, 1'b0, 3'd0, 2'd0, 4'h0, v, 1'b0);
  endtask

  task automatic t_reset;
    chk_eq("R1", "pc after reset", int'(pc), 0);
    chk_eq("R1", "sp after reset", int'(sp), 0);
    chk_eq("R1", "ready after reset", int'(cmd_ready), 1);
    chk_eq("R1", "req after reset", int'(mem_req), 0);
  endtask

  task automatic t_advance;
    int base = lg_n;
    issue(3'd0, 1'b0, 3'd0, 2'd3, 4'h0, 16'h0, 1'b0);
    chk_eq("R2", "pc after advance 3", int'(pc), 3);
    issue(3'd0, 1'b0, 3'd0, 2'd1, 4'h0, 16'h0, 1'b0);
    chk_eq("R2", "pc after advance 1", int'(pc), 4);
    chk_eq("R2", "memory cycles", lg_n - base, 0);
  endtask

  task automatic t_jump_abs;
    int base;
    set_pc(16'h0010);
    mem[8'h11] = 8'h34; mem[8'h12] = 8'h12;
    base = lg_n;
    issue(3'd1, 1'b0, 3'd0, 2'd0, 4'h0, 16'h0, 1'b0);
    chk_eq("R3", "jump target", int'(pc), 16'h1234);
    chk_eq("R3", "read count", lg_n - base, 2);
    chk_txn("R3", base, 16'h0011, 1'b0, 8'h34, 0);
    chk_txn("R3", base + 1, 16'h0012, 1'b0, 8'h12, 0);
  endtask

  task automatic t_jump_rel;
    int base;
    set_pc(16'h0020); mem[8'h21] = 8'h05;
    base = lg_n;
    issue(3'd3, 1'b0, 3'd0, 2'd0, 4'h0, 16'h0, 1'b0);
    chk_eq("R4", "forward rel", int'(pc), 16'h0027);
    chk_eq("R4", "rel reads", lg_n - base, 1);
    chk_txn("R4", base, 16'h0021, 1'b0, 8'h05, 0);
    set_pc(16'h0020); mem[8'h21] = 8'hF0;
    issue(3'd3, 1'b0, 3'd0, 2'd0, 4'h0, 16'h0, 1'b0);
    chk_eq("R4", "backward rel", int'(pc), 16'h0012);
    set_pc(16'hFFF0); mem[8'hF1] = 8'h20;
    issue(3'd3, 1'b0, 3'd0, 2'd0, 4'h0, 16'h0, 1'b0);
    chk_eq("R4", "wrapping rel", int'(pc), 16'h0012);
  endtask

  task automatic t_jump_w3;
    set_pc(16'hBEEF);
    chk_eq("R5", "jump through w3", int'(pc), 16'hBEEF);
    issue(3'd2, 1'b1, 3'd0, 2'd0, 4'h0, 16'h1111, 1'b0);
    chk_eq("R5", "skipped w3 jump", int'(pc), 16'hBEF0);
  endtask

  task automatic t_call_ret;
    int base;
    set_pc(16'h0030);
    mem[8'h31] = 8'h67; mem[8'h32] = 8'h45;
    base = lg_n;
    issue(3'd4, 1'b0, 3'd0, 2'd0, 4'h0, 16'h0, 1'b0);
    chk_eq("R6", "call target", int'(pc), 16'h4567);
    chk_eq("R6", "sp after call", int'(sp), 16'hFFFE);
    chk_eq("R6", "call cycles", lg_n - base, 4);
    chk_txn("R6", base + 2, 16'hFFFF, 1'b1, 8'h00, 2);
    chk_txn("R6", base + 3, 16'hFFFE, 1'b1, 8'h33, 2);
    base = lg_n;
    issue(3'd6, 1'b0, 3'd0, 2'd0, 4'h0, 16'h0, 1'b0);
    chk_eq("R7", "return address", int'(pc), 16'h0033);
    chk_eq("R7", "sp after return", int'(sp), 0);
    chk_eq("R7", "return cycles", lg_n - base, 2);
    chk_txn("R7", base, 16'hFFFE, 1'b0, 8'h33, 2);
    chk_txn("R7", base + 1, 16'hFFFF, 1'b0, 8'h00, 2);
    set_pc(16'h0040);
    base = lg_n;
    issue(3'd5, 1'b0, 3'd0, 2'd0, 4'h0, 16'h2222, 1'b0);
    chk_eq("R5", "call through w3", int'(pc), 16'h2222);
    chk_txn("R6", base + 1, 16'hFFFE, 1'b1, 8'h41, 2);
    issue(3'd6, 1'b0, 3'd0, 2'd0, 4'h0, 16'h0, 1'b0);
    chk_eq("R7", "return from w3 call", int'(pc), 16'h0041);
  endtask

  task automatic t_conditions;
    for (int code = 0; code < 8; code++) begin
      for (int fv = 0; fv < 2; fv++) begin
        logic [3:0] mask = 4'b0001 << (code >> 1);
        logic [3:0] fl = fv ? mask : ~mask;
        bit met = (fv != 0) ^ (code[0]);
        set_pc(16'h0100);
        issue(3'd2, 1'b1, code[2:0], 2'd0, fl, 16'h0ABC, 1'b0);
        chk_eq("R8", $sformatf("cond %0d flag %0d", code, fv), int'(pc),
               met ? 16'h0ABC : 16'h0101);
      end
    end
  endtask

  task automatic t_flag_sample;
    set_pc(16'h0060); mem[8'h61] = 8'h00; mem[8'h62] = 8'h70;
    issue(3'd1, 1'b1, 3'd0, 2'd0, 4'b0001, 16'h0, 1'b1);
    chk_eq("R8", "flags taken at accept (met)", int'(pc), 16'h7000);
    set_pc(16'h0060);
    issue(3'd1, 1'b1, 3'd0, 2'd0, 4'b0000, 16'h0, 1'b1);
    chk_eq("R8", "flags taken at accept (unmet)", int'(pc), 16'h0063);
  endtask

  task automatic t_not_taken;
    int base;
    set_pc(16'h0050);
    base = lg_n;
    issue(3'd4, 1'b1, 3'd1, 2'd0, 4'b0001, 16'h0, 1'b0);
    chk_eq("R9", "skipped call pc", int'(pc), 16'h0053);
    chk_eq("R9", "skipped call sp", int'(sp), 0);
    chk_eq("R9", "skipped call cycles", lg_n - base, 2);
    chk_txn("R9", base + 1, 16'h0052, 1'b0, int'(mem[8'h52]), 0);
    base = lg_n;
    issue(3'd6, 1'b1, 3'd2, 2'd0, 4'b0000, 16'h0, 1'b0);
    chk_eq("R9", "skipped return pc", int'(pc), 16'h0054);
    chk_eq("R9", "skipped return cycles", lg_n - base, 0);
    mem[8'h55] = 8'h10;
    issue(3'd3, 1'b1, 3'd6, 2'd0, 4'b0000, 16'h0, 1'b0);
    chk_eq("R9", "skipped rel pc", int'(pc), 16'h0056);
  endtask

  task automatic t_reserved;
    int base;
    set_pc(16'h0200);
    base = lg_n;
    issue(3'd7, 1'b0, 3'd0, 2'd3, 4'h0, 16'h0, 1'b0);
    chk_eq("R11", "reserved code pc", int'(pc), 16'h0201);
    chk_eq("R11", "reserved code cycles", lg_n - base, 0);
  endtask

  task automatic t_backpressure;
    int base;
    bit early = 1'b0;
    set_pc(16'h0070);
    mem[8'h71] = 8'h00; mem[8'h72] = 8'h90;
    base = lg_n;
    @(negedge clk);
    cmd_op = 3'd4; cmd_cond_en = 1'b0; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_op = 3'd0; cmd_len = 2'd1;
    while (!cmd_ready) begin
      if (pc != 16'h0070) early = 1'b1;
      @(negedge clk);
    end
    chk_eq("R10", "pc frozen while busy", int'(early), 0);
    chk_eq("R10", "call done before next", int'(pc), 16'h9000);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk_eq("R10", "held command lands once", int'(pc), 16'h9001);
    chk_eq("R10", "cycle count", lg_n - base, 4);
    issue(3'd6, 1'b0, 3'd0, 2'd0, 4'h0, 16'h0, 1'b0);
    chk_eq("R10", "return after held", int'(pc), 16'h0073);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_advance;
    t_jump_abs;
    t_jump_rel;
    t_jump_w3;
    t_call_ret;
    t_conditions;
    t_flag_sample;
    t_not_taken;
    t_reserved;
    t_backpressure;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule